// File: doc/BRIEF.md
# Latched Vectored Interrupt Controller

This block gathers eight hardware interrupt sources into a set of sticky pending flags. It filters those flags through a software-written enable mask and drives a single request line to the processor. Each source delivers its event as a one-cycle pulse. That pulse marks the source's flag as pending, and the flag stays set until software writes a one to that bit through the acknowledge port. The request line is the OR of every flag that is both pending and enabled.

Alongside the request, the block drives a vector number. It equals a software-programmed base plus the bit number of the highest-numbered source that is both pending and enabled. The processor takes this number when it accepts the interrupt. Software sees three byte-wide registers on a simple I/O bus: the vector base, the enable mask and the pending/acknowledge port. The bus interface is plain control and status with no stream traffic, so it has no valid/ready handshake and no back-pressure. A write happens on any clock edge where `wr_en` is high, and read data is a combinational function of the address.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `src_evt` sets pending bit i at the next clock edge, whether or not enable bit i is set. Source bit positions are: 7 horizontal-blank timer, 6 vertical-blank start, 5 vertical-blank timer, 4 line match, 3 serial receive, 2 alarm, 1 key, 0 serial transmit.
- R2: A write to the pending port (address 0xB6) clears every pending bit whose data bit is 1 and leaves every pending bit whose data bit is 0 unchanged.
- R3: If a source event and a clear for the same bit fall in the same cycle, the bit is set after that edge.
- R4: `irq_req` is high exactly when the bitwise AND of pending and enable is nonzero.
- R5: While `irq_req` is high, `irq_vec` equals the base register plus the index (0 to 7) of the highest-numbered set bit of pending AND enable, modulo 256.
- R6: Writes to address 0xB0 load the vector base, and writes to 0xB2 load the enable mask. Reading 0xB0, 0xB2 or 0xB6 returns the base, the enable mask or the raw pending bits respectively.
- R7: After reset, base, enable and pending are all 0 and `irq_req` is low.
- R8: A masked source's pending bit stays latched. Once software sets its enable bit, `irq_req` is high in the cycle after that write.
- R9: Writes to any other address change no register, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 8 | One-cycle event pulses, one per source |
| bus_addr | input | 8 | I/O register address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 8 | Vector number of the winning source |

## Verification
The hardest case to reach from the ports is an event arriving in the very cycle that software clears the same bit. Close behind it is a flag that latched while masked and then becomes visible when its enable is written. Random stimulus alone seldom lines these up, so directed steps force each one: a write-one-to-clear paired with a same-cycle pulse, and an event with enable at zero followed by a write that sets the enable bit. These steps sit alongside bases near 0xFF, which make the vector wrap. A long run with a fixed seed then mixes sparse random pulses with writes to mapped and unmapped addresses, all checked against a bench model.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NSRC  = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 8;
  localparam int unsigned IDX_W = $clog2(NSRC);

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [DW-1:0]   byte_t;
  typedef logic [AW-1:0]   addr_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter addr_t ADDR_BASE = 8'hB0,
  parameter addr_t ADDR_MASK = 8'hB2,
  parameter addr_t ADDR_PEND = 8'hB6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  addr_t    bus_addr,
  input  logic     wr_en,
  input  byte_t    wr_data,
  input  src_vec_t pend,
  output byte_t    vec_base,
  output src_vec_t en_mask,
  output src_vec_t clr_mask,
  output byte_t    rd_data
);
  logic hit_base, hit_mask, hit_pend;

  assign hit_base = (bus_addr == ADDR_BASE);
  assign hit_mask = (bus_addr == ADDR_MASK);
  assign hit_pend = (bus_addr == ADDR_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_base <= '0;
      en_mask  <= '0;
    end else if (wr_en) begin
      if (hit_base) vec_base <= wr_data;
      if (hit_mask) en_mask  <= wr_data[NSRC-1:0];
    end
  end

  assign clr_mask = (wr_en && hit_pend) ? wr_data[NSRC-1:0] : '0;

  always_comb begin
    rd_data = '0;
    if (hit_base)      rd_data = vec_base;
    else if (hit_mask) rd_data = byte_t'(en_mask);
    else if (hit_pend) rd_data = byte_t'(pend);
  end

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_mask) |=> (en_mask == $past(wr_data[NSRC-1:0])));
  a_r6_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_base) |=> (vec_base == $past(wr_data)));
  a_r9_other_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (hit_base || hit_mask))) |=> ($stable(vec_base) && $stable(en_mask)));
endmodule

// File: rtl/irq_vec_pending.sv
module irq_vec_pending
  import irq_vec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t src_evt,
  input  src_vec_t clr_mask,
  output src_vec_t pend
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= src_evt[g] | (pend[g] & ~clr_mask[g]);
    end
  end

  // R1 and R3: an event always leaves its bit set
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((pend & $past(src_evt)) == $past(src_evt)));
  a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr_mask & ~src_evt)) == '0));
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask)));
endmodule

// File: rtl/irq_vec_prio.sv
module irq_vec_prio
  import irq_vec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t pend,
  input  src_vec_t en_mask,
  input  byte_t    vec_base,
  output logic     irq_req,
  output byte_t    irq_vec
);
  src_vec_t req;
  idx_t     win_idx;
  logic     any;

  assign req = pend & en_mask;

  always_comb begin
    win_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) begin
        win_idx = idx_t'(i);
        any     = 1'b1;
      end
    end
  end

  assign irq_req = any;
  assign irq_vec = vec_base + byte_t'(win_idx);

  a_r5_highest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((req >> win_idx) == src_vec_t'(1)));
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (req == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'hB0,
  parameter logic [7:0] ADDR_MASK = 8'hB2,
  parameter logic [7:0] ADDR_PEND = 8'hB6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] src_evt,
  input  logic [7:0] bus_addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq_req,
  output logic [7:0] irq_vec
);
  src_vec_t pend, en_mask, clr_mask;
  byte_t    vec_base;

  irq_vec_regs #(
    .ADDR_BASE(ADDR_BASE), .ADDR_MASK(ADDR_MASK), .ADDR_PEND(ADDR_PEND)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .pend(pend), .vec_base(vec_base),
    .en_mask(en_mask), .clr_mask(clr_mask), .rd_data(rd_data)
  );

  irq_vec_pending u_pend (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .clr_mask(clr_mask), .pend(pend)
  );

  irq_vec_prio u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en_mask(en_mask),
    .vec_base(vec_base), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // R8: a write that enables an already latched bit raises the request
  a_r8_enable_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == ADDR_MASK && ((pend & wr_data) != '0)) |=> irq_req);
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_evt = '0, bus_addr = '0, wr_data = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data, irq_vec;
  logic       irq_req;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_base = '0, m_en = '0, m_pend = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] exp_vec(logic [7:0] b, logic [7:0] r);
    logic [7:0] v = b;
    for (int i = 0; i < 8; i++) if (r[i]) v = b + 8'(i);
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == 8'hB0) return m_base;
    if (a == 8'hB2) return m_en;
    if (a == 8'hB6) return m_pend;
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // drive one cycle at negedge, update model, check after the edge
  task automatic step(logic [7:0] ev, logic w, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    src_evt = ev; wr_en = w; bus_addr = a; wr_data = d;
    @(posedge clk); #1;
    if (w && a == 8'hB0) m_base = d;
    if (w && a == 8'hB2) m_en = d;
    m_pend = ev | (m_pend & ~((w && a == 8'hB6) ? d : 8'h00));
    check("R4 irq_req", {7'd0, irq_req}, {7'd0, |(m_pend & m_en)});
    if (|(m_pend & m_en)) check("R5 irq_vec", irq_vec, exp_vec(m_base, m_pend & m_en));
    check("R6/R9 rd_data", rd_data, exp_rd(a));
    src_evt = '0; wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); bus_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R7 irq after reset", {7'd0, irq_req}, 8'd0);
    rd(8'hB0, 8'h00, "R7 base reset");
    rd(8'hB2, 8'h00, "R7 mask reset");
    rd(8'hB6, 8'h00, "R7 pend reset");
    @(negedge clk); rst_n = 1'b1;

    // R1 / R8: masked source latches, then enabled
    step(8'h40, 1'b0, 8'hB6, 8'h00);
    check("R1 masked latch", rd_data, 8'h40);
    check("R8 no irq while masked", {7'd0, irq_req}, 8'd0);
    step(8'h00, 1'b1, 8'hB0, 8'h20);
    step(8'h00, 1'b1, 8'hB2, 8'h40);
    check("R8 irq after enable", {7'd0, irq_req}, 8'd1);
    check("R5 base 20 + 6", irq_vec, 8'h26);
    // R2: zero bits keep, one bits clear
    step(8'h81, 1'b1, 8'hB6, 8'h00);
    rd(8'hB6, 8'hC1, "R2 write zero keeps");
    step(8'h00, 1'b1, 8'hB6, 8'h41);
    rd(8'hB6, 8'h80, "R2 write one clears");
    // R3: event wins over same-cycle clear
    step(8'h80, 1'b1, 8'hB6, 8'h80);
    rd(8'hB6, 8'h80, "R3 event beats clear");
    // R5 wrap
    step(8'h00, 1'b1, 8'hB2, 8'hFF);
    step(8'h00, 1'b1, 8'hB0, 8'hFC);
    check("R5 wrap FC+7", irq_vec, 8'h03);
    // R9 unmapped write/read
    step(8'h00, 1'b1, 8'hB1, 8'h5A);
    rd(8'hB1, 8'h00, "R9 unmapped read");
    rd(8'hB0, 8'hFC, "R9 base untouched");
    rd(8'hB2, 8'hFF, "R9 mask untouched");
    step(8'h00, 1'b1, 8'hB6, 8'hFF);
    check("R4 irq low when none pending", {7'd0, irq_req}, 8'd0);

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ev, a;
      logic [2:0] sel;
      ev  = ($urandom % 4 == 0) ? (8'd1 << ($urandom % 8)) : 8'h00;
      sel = 3'($urandom);
      case (sel)
        3'd0:    a = 8'hB0;
        3'd1:    a = 8'hB2;
        3'd2, 3'd3, 3'd4: a = 8'hB6;
        default: a = 8'($urandom);
      endcase
      step(ev, ($urandom % 3) == 0, a, 8'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule